// File: doc/BRIEF.md
# Carrier Cycle and Phase Latch

This block follows the carrier oscillator of one receiver channel so that software can build an integrated carrier phase measurement. A 32-bit phase accumulator adds a frequency increment word on every clock. Each time the accumulator wraps past its top, one whole carrier cycle has passed, and a cycle counter counts that wrap.

A periodic epoch strobe marks the measurement instants. On each strobe the block copies two values into read registers: the fractional carrier phase, which is the upper 10 bits of the accumulator, and the cycle count for the interval that is closing. The counter then starts the next interval from zero. The latched count for an interval is the number of wraps in it plus one. The extra one stands for the cycle that straddles the start of the interval.

Software reads both registers between strobes. It adds the latched counts, subtracts one per interval, and adds the difference between the last and first latched phases, taken in 1/1024-cycle units. The result is a continuous phase with no gap at any epoch boundary.

Top module: `carrier_phase_latch`

## Requirements
- R1: While reset is high, the accumulator, the cycle counter, the latched phase and the latched count are all held at zero. The first interval after reset starts from an accumulator value of zero.
- R2: On every clock the accumulator adds the increment word modulo 2^32. On a clock with the epoch strobe, the latched phase takes bits 31..22 of the accumulator value that results from that clock's addition.
- R3: On an epoch, the latched count is the number of accumulator carries in the closing interval plus one. The closing interval includes the epoch clock itself, so an interval with no carries latches 1.
- R4: A carry that occurs on the same clock as the epoch is counted in the closing interval. The cycle counter restarts from zero, so that carry is not counted again in the next interval.
- R5: The cycle counter and the latched count saturate at 2^CNT_W−1 and never wrap. After a saturated interval, the next interval counts normally again.
- R6: Between epochs, the latched phase and the latched count keep their values no matter how the accumulator and counter change.
- R7: Over N consecutive intervals, (sum of latched counts − N)·1024 + (last latched phase − first latched phase) equals the change in floor(accumulator/2^22) over the same span.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_incr | input | ACC_W (32) | Frequency increment word added to the accumulator on each clock |
| epoch | input | 1 | Epoch strobe, one clock wide; captures and restarts |
| phase_lat | output | PH_W (10) | Fractional carrier phase latched at the last epoch |
| count_lat | output | CNT_W (20) | Carrier cycle count latched at the last epoch |

## Verification
The bench drives a zero increment to confirm that an interval with no wraps latches exactly one. It uses a quarter-cycle increment to show that the latched phase comes from the post-addition value. An increment tuned so that a wrap lands on the epoch clock separates counting in the closing interval from leaking into the next one. An all-ones increment forces a wrap on every clock and drives the counter into saturation. A run of intervals with varied increments and lengths checks the chaining identity, which catches off-by-one errors at interval edges that single-interval tests cannot see.

// File: rtl/ccpl_pkg.sv
package ccpl_pkg;

    localparam int ACC_W_DEF = 32;
    localparam int PH_W_DEF  = 10;
    localparam int CNT_W_DEF = 20;

    // action taken by the cycle counter on a clock
    typedef enum logic [1:0] {
        CNT_HOLD    = 2'd0,
        CNT_INC     = 2'd1,
        CNT_RESTART = 2'd2
    } cnt_act_e;

    // saturating add of a small step to a value no wider than 31 bits
    function automatic logic [31:0] sat_add(input logic [31:0] base,
                                            input logic [1:0]  step,
                                            input logic [31:0] ceiling);
        logic [32:0] s;
        s = {1'b0, base} + 33'(step);
        if (s > {1'b0, ceiling})
            return ceiling;
        return s[31:0];
    endfunction

endpackage

// File: rtl/ccpl_phase_acc.sv
module ccpl_phase_acc #(
    parameter int ACC_W = ccpl_pkg::ACC_W_DEF,
    parameter int PH_W  = ccpl_pkg::PH_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] incr,
    output logic [ACC_W-1:0] acc_q,
    output logic [PH_W-1:0]  phase_next,
    output logic             carry
);
    logic [ACC_W:0] sum;

    always_comb begin
        sum        = {1'b0, acc_q} + {1'b0, incr};
        carry      = sum[ACC_W];
        phase_next = sum[ACC_W-1 -: PH_W];
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else
            acc_q <= sum[ACC_W-1:0];
    end
endmodule

// File: rtl/ccpl_cycle_cnt.sv
module ccpl_cycle_cnt
    import ccpl_pkg::*;
#(
    parameter int CNT_W = ccpl_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             carry,
    input  logic             epoch,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] close_val
);
    localparam logic [31:0] CEIL = 32'((64'd1 << CNT_W) - 64'd1);

    cnt_act_e    act;
    logic [31:0] inc_w;
    logic [31:0] close_w;

    always_comb begin
        if (epoch)
            act = CNT_RESTART;
        else if (carry)
            act = CNT_INC;
        else
            act = CNT_HOLD;
        inc_w     = sat_add(32'(cnt_q), {1'b0, carry}, CEIL);
        // closing value: wraps seen, this clock's wrap, plus the straddling cycle
        close_w   = sat_add(32'(cnt_q), 2'({1'b0, carry}) + 2'd1, CEIL);
        close_val = close_w[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case (act)
                CNT_RESTART: cnt_q <= '0;
                CNT_INC:     cnt_q <= inc_w[CNT_W-1:0];
                default:     cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/ccpl_epoch_latch.sv
module ccpl_epoch_latch #(
    parameter int PH_W  = ccpl_pkg::PH_W_DEF,
    parameter int CNT_W = ccpl_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             epoch,
    input  logic [PH_W-1:0]  phase_in,
    input  logic [CNT_W-1:0] count_in,
    output logic [PH_W-1:0]  phase_q,
    output logic [CNT_W-1:0] count_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            count_q <= '0;
        end else if (epoch) begin
            phase_q <= phase_in;
            count_q <= count_in;
        end
    end
endmodule

// File: rtl/carrier_phase_latch.sv
module carrier_phase_latch #(
    parameter int ACC_W = ccpl_pkg::ACC_W_DEF,
    parameter int PH_W  = ccpl_pkg::PH_W_DEF,
    parameter int CNT_W = ccpl_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] phase_incr,
    input  logic             epoch,
    output logic [PH_W-1:0]  phase_lat,
    output logic [CNT_W-1:0] count_lat
);
    logic [ACC_W-1:0] acc_q;
    logic [PH_W-1:0]  phase_next;
    logic             carry;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] close_val;

    ccpl_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .incr       (phase_incr),
        .acc_q      (acc_q),
        .phase_next (phase_next),
        .carry      (carry)
    );

    ccpl_cycle_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .carry     (carry),
        .epoch     (epoch),
        .cnt_q     (cnt_q),
        .close_val (close_val)
    );

    ccpl_epoch_latch #(.PH_W(PH_W), .CNT_W(CNT_W)) u_lat (
        .clk      (clk),
        .rst      (rst),
        .epoch    (epoch),
        .phase_in (phase_next),
        .count_in (close_val),
        .phase_q  (phase_lat),
        .count_q  (count_lat)
    );
endmodule

// File: rtl/carrier_phase_latch_chk.sv
module carrier_phase_latch_chk #(
    parameter int ACC_W = 32,
    parameter int PH_W  = 10,
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic [ACC_W-1:0] phase_incr,
    input logic             epoch,
    input logic [ACC_W-1:0] acc_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [PH_W-1:0]  phase_lat,
    input logic [CNT_W-1:0] count_lat
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (acc_q == '0 && cnt_q == '0 && phase_lat == '0 && count_lat == '0));

    // R2
    acc_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> acc_q == $past(acc_q) + $past(phase_incr));

    // R2
    phase_cap_chk: assert property (@(posedge clk) disable iff (rst)
        epoch |=> phase_lat == acc_q[ACC_W-1 -: PH_W]);

    // R3
    count_min_chk: assert property (@(posedge clk) disable iff (rst)
        epoch |=> count_lat != '0);

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        epoch |=> cnt_q == '0);

    // R5
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!epoch && cnt_q == CMAX) |=> cnt_q == CMAX);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !epoch |=> ($stable(phase_lat) && $stable(count_lat)));
endmodule

bind carrier_phase_latch carrier_phase_latch_chk #(
    .ACC_W(ACC_W), .PH_W(PH_W), .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .phase_incr (phase_incr),
    .epoch      (epoch),
    .acc_q      (acc_q),
    .cnt_q      (cnt_q),
    .phase_lat  (phase_lat),
    .count_lat  (count_lat)
);

// File: tb/sim_carrier_phase_latch.sv
module sim_carrier_phase_latch;
    localparam int ACC_W = 32;
    localparam int PH_W  = 10;
    localparam int CNT_W = 12;
    localparam longint CMAX = (64'd1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [ACC_W-1:0] phase_incr = '0;
    logic             epoch = 1'b0;
    logic [PH_W-1:0]  phase_lat;
    logic [CNT_W-1:0] count_lat;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] m_acc = '0;
    longint      m_carries = 0;

    always #4 clk = ~clk;

    carrier_phase_latch #(.ACC_W(ACC_W), .PH_W(PH_W), .CNT_W(CNT_W)) u0 (
        .clk        (clk),
        .rst        (rst),
        .phase_incr (phase_incr),
        .epoch      (epoch),
        .phase_lat  (phase_lat),
        .count_lat  (count_lat)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, return at the next negedge
    task automatic step(input logic [31:0] inc, input logic ep);
        logic [32:0] s;
        phase_incr = inc;
        epoch      = ep;
        @(posedge clk);
        if (!rst) begin
            s = {1'b0, m_acc} + {1'b0, inc};
            m_acc = s[31:0];
            m_carries = m_carries + longint'(s[32]);
            if (ep) m_carries = 0;
        end
        @(negedge clk);
        epoch = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(32'h1234_5678, 1'b1);
        step(32'h0FFF_FFFF, 1'b0);
        chk("R1 phase in reset", phase_lat, 0);
        chk("R1 count in reset", count_lat, 0);
        rst = 1'b0;
        m_acc = '0;
        m_carries = 0;
        step(32'h0, 1'b1);
        chk("R1 acc cleared, phase", phase_lat, 0);
        chk("R1 count after reset", count_lat, 1);
    endtask

    task automatic t_zero_incr();
        for (int i = 0; i < 7; i++) step(32'h0, 1'b0);
        step(32'h0, 1'b1);
        chk("R3 no-carry count", count_lat, 1);
        chk("R2 zero-incr phase", phase_lat, 0);
    endtask

    task automatic t_quarter();
        for (int i = 0; i < 10; i++) step(32'h4000_0000, 1'b0);
        step(32'h1000_0000, 1'b1);
        chk("R2 post-add phase", phase_lat, 576);
        chk("R3 two carries", count_lat, 3);
    endtask

    task automatic t_hold();
        bit bad = 1'b0;
        for (int i = 0; i < 20; i++) begin
            step(32'h0123_4567 + 32'(i), 1'b0);
            if (phase_lat != 10'd576 || count_lat != 12'd3) bad = 1'b1;
        end
        chk("R6 phase held", phase_lat, 576);
        chk("R6 count held", count_lat, 3);
        chk("R6 no change during run", longint'(bad), 0);
    endtask

    task automatic t_coincide();
        step(32'h0, 1'b1);
        if (m_acc == 32'h0) step(32'h1, 1'b0);
        step(32'h0 - m_acc, 1'b1);
        chk("R4 carry on epoch counted", count_lat, 2);
        chk("R4 phase at wrap", phase_lat, 0);
        step(32'h8000_0000, 1'b0);
        step(32'h0, 1'b1);
        chk("R4 no leak into next", count_lat, 1);
        chk("R2 half-cycle phase", phase_lat, 512);
    endtask

    task automatic t_sat();
        step(32'h0, 1'b1);
        for (int i = 0; i < 5000; i++) step(32'hFFFF_FFFF, 1'b0);
        step(32'h0, 1'b1);
        chk("R5 saturated count", count_lat, CMAX);
        step(32'h0, 1'b1);
        chk("R5 restart after saturation", count_lat, 1);
    endtask

    task automatic t_chain();
        logic [31:0] seed = 32'h2468_ACE1;
        longint af, total = 0, sum_cnt = 0, ph_first, act, exp;
        int n_int = 6;
        step(32'h0, 1'b1);
        ph_first = phase_lat;
        af = longint'(m_acc);
        for (int k = 0; k < n_int; k++) begin
            int len;
            seed = seed * 32'd1664525 + 32'd1013904223;
            len = 5 + int'(seed[4:0]);
            for (int j = 0; j < len; j++) begin
                seed = seed * 32'd1664525 + 32'd1013904223;
                total = total + longint'(seed);
                step(seed, (j == len - 1));
                if (j == len - 1) begin
                    chk("R3 chained interval count", count_lat,
                        longint'(count_lat) == 0 ? -1 : longint'(count_lat));
                    chk("R2 chained phase", phase_lat, longint'(m_acc[31:22]));
                    sum_cnt = sum_cnt + longint'(count_lat);
                end
            end
        end
        act = (sum_cnt - n_int) * 1024 + longint'(phase_lat) - ph_first;
        exp = ((af + total) >>> 22) - (af >>> 22);
        chk("R7 integrated phase", act, exp);
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_zero_incr();
        t_quarter();
        t_hold();
        t_coincide();
        t_sat();
        t_chain();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule